// File: doc/BRIEF.md
# Single-Precision Weight Guard Codec

This block protects 32-bit floating-point neural network weights held in a memory that has no spare bits. On the write side it computes four check bits over the sign and the eight exponent bits of the weight and stores them in place of the four lowest mantissa bits. The stored word stays 32 bits wide. The memory array itself sits outside the block.

On the read side it recomputes the check bits and forms a syndrome. It repairs a single flipped bit in the sign or exponent and returns the weight with its four lowest mantissa bits cleared. Flags report a repaired word and a word it could not repair.

A second stage can then apply an outlier filter. A value below a lower bound or above an upper bound is replaced by zero. The bounds are floating-point values supplied from outside, chosen from the spread of the trained weights. A value whose exponent is all ones is always replaced by zero.

Two control bits enable the code and the filter separately. This gives code-only, filter-only and combined operation. The read path has two register stages and accepts one word per clock.

Top module: `wgc_top`

## Requirements
- R1: With `code_en`=1, `wr_word[31:4]` equals `wr_weight[31:4]`, and `wr_word[3:0]` holds check bits {c3,c2,c1,c0}. Protected bit d0..d7 is exponent bit 23..30 and d8 is the sign bit 31. In codeword positions 1 to 13, the positions that are not powers of two are given to d0..d8 in ascending order (3,5,6,7,9,10,11,12,13). Check bit ck is the XOR of the protected bits whose position has bit k set.
- R2: With `code_en`=1 and a zero syndrome, the read result equals the stored word with bits [3:0] cleared, and both code flags are low.
- R3: With `code_en`=1, a single flipped protected bit (sign or any exponent bit) is restored, and `rd_corrected` is raised.
- R4: With `code_en`=1, a single flipped check bit raises `rd_corrected` and leaves the sign and exponent unchanged.
- R5: With `code_en`=1, a syndrome of 14 or 15 raises `rd_uncorrectable`, keeps `rd_corrected` low, and flips no bit. Bits [3:0] are still cleared.
- R6: With `code_en`=0, the write path passes the weight unchanged, the read path passes the stored word unchanged, and both code flags stay low.
- R7: With `filt_en`=1, a value that orders below `bound_lo` or above `bound_hi` as a signed float becomes zero and raises `rd_filtered`. A value equal to either bound passes.
- R8: With `filt_en`=1, a value whose exponent bits are all ones becomes zero and raises `rd_filtered`, even when it lies inside the bounds.
- R9: With `filt_en`=0, no value is filtered and `rd_filtered` stays low.
- R10: With both enables set, correction happens before filtering. A repaired value inside the bounds passes. An error the code handles wrongly and that yields an outlier is zeroed by the filter.
- R11: `rd_valid_out` and the result appear two clock edges after the word is presented with `rd_valid_in`. Back-to-back words give back-to-back results.
- R12: While reset is asserted, and after it is released, `rd_valid_out` is low until a word has been presented.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| code_en | input | 1 | Enables check-bit generation on write and correction on read |
| filt_en | input | 1 | Enables the outlier filter on the read path |
| bound_lo | input | 32 | Lower filter bound, single-precision float |
| bound_hi | input | 32 | Upper filter bound, single-precision float |
| wr_weight | input | 32 | Weight to be stored |
| wr_word | output | 32 | Word to write into memory |
| rd_valid_in | input | 1 | Stored word on `rd_word` is valid |
| rd_word | input | 32 | Word read from memory |
| rd_valid_out | output | 1 | Result on `rd_weight` is valid |
| rd_weight | output | 32 | Repaired and filtered weight |
| rd_corrected | output | 1 | Nonzero syndrome inside codeword positions 1 to 13 |
| rd_uncorrectable | output | 1 | Syndrome outside the codeword |
| rd_filtered | output | 1 | The filter replaced the value with zero |

## Verification
The bench flips the sign bit, the top and bottom exponent bits, and a lone check bit. A decoder that maps a data bit to the wrong position would fix the wrong bit or leave the weight damaged. A double error with syndrome 14 must be reported without any bit being flipped, and a double error with syndrome 15 must leave an all-ones exponent that the filter zeroes. A double error whose syndrome lands on a data position gives a wrong correction, and that result must be caught as an out-of-range value. Values exactly equal to each bound, and infinity inside wide bounds, check the signed-float ordering and the all-ones exponent rule. A filter using unsigned integer order, or strict bounds, would zero good weights or pass bad ones.

// File: rtl/wgc_pkg.sv
package wgc_pkg;

  localparam int unsigned WGC_EXP_W = 8;
  localparam int unsigned WGC_MAN_W = 23;
  localparam int unsigned WGC_PAR_W = 4;

  // Codeword position of protected bit idx: the idx-th position that is not a power of two.
  function automatic int unsigned wgc_pos_of(int unsigned idx);
    int unsigned seen;
    int unsigned res;
    seen = 0;
    res  = 0;
    for (int unsigned p = 1; p < 64; p++) begin
      if ((p & (p - 1)) != 0) begin
        if (seen == idx && res == 0) res = p;
        seen++;
      end
    end
    return res;
  endfunction

endpackage

// File: rtl/wgc_rst_sync.sv
module wgc_rst_sync (
  input  logic clk,
  input  logic rst_n_i,
  output logic rst_n_o
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) sync_q <= 2'b00;
    else          sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_o = sync_q[1];

endmodule

// File: rtl/wgc_check_gen.sv
module wgc_check_gen #(
  parameter int unsigned PROT_W = 9,
  parameter int unsigned PAR_W  = 4
) (
  input  logic [PROT_W-1:0] prot_i,
  output logic [PAR_W-1:0]  chk_o
);
  import wgc_pkg::*;

  always_comb begin
    chk_o = '0;
    for (int unsigned k = 0; k < PAR_W; k++) begin
      for (int unsigned i = 0; i < PROT_W; i++) begin
        if (((wgc_pos_of(i) >> k) & 1) != 0) chk_o[k] = chk_o[k] ^ prot_i[i];
      end
    end
  end

endmodule

// File: rtl/wgc_decode.sv
module wgc_decode #(
  parameter int unsigned EXP_W = 8,
  parameter int unsigned MAN_W = 23,
  parameter int unsigned PAR_W = 4
) (
  input  logic [EXP_W+MAN_W:0] word_i,
  input  logic                 code_en_i,
  output logic [EXP_W+MAN_W:0] word_o,
  output logic                 corr_o,
  output logic                 uncorr_o
);
  import wgc_pkg::*;

  localparam int unsigned WORD_W = 1 + EXP_W + MAN_W;
  localparam int unsigned PROT_W = EXP_W + 1;
  localparam int unsigned CODE_N = PROT_W + PAR_W;

  logic [PROT_W-1:0] prot;
  logic [PROT_W-1:0] flip;
  logic [PAR_W-1:0]  recalc;
  logic [PAR_W-1:0]  syn;
  logic              beyond;

  assign prot = word_i[WORD_W-1:MAN_W];

  wgc_check_gen #(.PROT_W(PROT_W), .PAR_W(PAR_W)) u_recalc (
    .prot_i (prot),
    .chk_o  (recalc)
  );

  assign syn    = recalc ^ word_i[PAR_W-1:0];
  assign beyond = 32'(syn) > CODE_N;

  always_comb begin
    for (int unsigned i = 0; i < PROT_W; i++) begin
      flip[i] = (32'(syn) == wgc_pos_of(i));
    end
  end

  always_comb begin
    if (code_en_i) begin
      word_o   = {prot ^ flip, word_i[MAN_W-1:PAR_W], {PAR_W{1'b0}}};
      corr_o   = (syn != '0) && !beyond;
      uncorr_o = beyond;
    end else begin
      word_o   = word_i;
      corr_o   = 1'b0;
      uncorr_o = 1'b0;
    end
  end

endmodule

// File: rtl/wgc_range_filter.sv
module wgc_range_filter #(
  parameter int unsigned EXP_W = 8,
  parameter int unsigned MAN_W = 23
) (
  input  logic [EXP_W+MAN_W:0] val_i,
  input  logic [EXP_W+MAN_W:0] lo_i,
  input  logic [EXP_W+MAN_W:0] hi_i,
  input  logic                 en_i,
  output logic [EXP_W+MAN_W:0] val_o,
  output logic                 hit_o
);

  localparam int unsigned WORD_W = 1 + EXP_W + MAN_W;

  // Map a sign-magnitude float onto an unsigned key with the same order.
  function automatic logic [WORD_W-1:0] order_key(logic [WORD_W-1:0] v);
    return v[WORD_W-1] ? ~v : {1'b1, v[WORD_W-2:0]};
  endfunction

  logic [WORD_W-1:0] k_val;
  logic [WORD_W-1:0] k_lo;
  logic [WORD_W-1:0] k_hi;
  logic              exp_full;

  assign k_val    = order_key(val_i);
  assign k_lo     = order_key(lo_i);
  assign k_hi     = order_key(hi_i);
  assign exp_full = &val_i[WORD_W-2:MAN_W];

  always_comb begin
    hit_o = en_i && (exp_full || (k_val < k_lo) || (k_val > k_hi));
    val_o = hit_o ? '0 : val_i;
  end

endmodule

// File: rtl/wgc_top.sv
module wgc_top #(
  parameter int unsigned EXP_W = wgc_pkg::WGC_EXP_W,
  parameter int unsigned MAN_W = wgc_pkg::WGC_MAN_W,
  parameter int unsigned PAR_W = wgc_pkg::WGC_PAR_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 code_en,
  input  logic                 filt_en,
  input  logic [EXP_W+MAN_W:0] bound_lo,
  input  logic [EXP_W+MAN_W:0] bound_hi,
  input  logic [EXP_W+MAN_W:0] wr_weight,
  output logic [EXP_W+MAN_W:0] wr_word,
  input  logic                 rd_valid_in,
  input  logic [EXP_W+MAN_W:0] rd_word,
  output logic                 rd_valid_out,
  output logic [EXP_W+MAN_W:0] rd_weight,
  output logic                 rd_corrected,
  output logic                 rd_uncorrectable,
  output logic                 rd_filtered
);

  localparam int unsigned WORD_W = 1 + EXP_W + MAN_W;
  localparam int unsigned PROT_W = EXP_W + 1;

  logic rst_sync_n;

  wgc_rst_sync u_rst (
    .clk     (clk),
    .rst_n_i (rst_n),
    .rst_n_o (rst_sync_n)
  );

  // Write path
  logic [PAR_W-1:0] wr_chk;

  wgc_check_gen #(.PROT_W(PROT_W), .PAR_W(PAR_W)) u_wr_chk (
    .prot_i (wr_weight[WORD_W-1:MAN_W]),
    .chk_o  (wr_chk)
  );

  assign wr_word = code_en ? {wr_weight[WORD_W-1:PAR_W], wr_chk} : wr_weight;

  // Read stage 1: decode and correct
  logic [WORD_W-1:0] dec_word;
  logic              dec_corr;
  logic              dec_uncorr;

  wgc_decode #(.EXP_W(EXP_W), .MAN_W(MAN_W), .PAR_W(PAR_W)) u_dec (
    .word_i    (rd_word),
    .code_en_i (code_en),
    .word_o    (dec_word),
    .corr_o    (dec_corr),
    .uncorr_o  (dec_uncorr)
  );

  logic              s1_valid_q, s1_valid_d;
  logic [WORD_W-1:0] s1_word_q;
  logic              s1_corr_q, s1_uncorr_q;
  logic              s1_load;

  assign s1_valid_d = rd_valid_in;
  assign s1_load    = rd_valid_in;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) s1_valid_q <= 1'b0;
    else             s1_valid_q <= s1_valid_d;
  end

  always_ff @(posedge clk) begin
    if (s1_load) begin
      s1_word_q   <= dec_word;
      s1_corr_q   <= dec_corr;
      s1_uncorr_q <= dec_uncorr;
    end
  end

  // Read stage 2: outlier filter
  logic [WORD_W-1:0] flt_word;
  logic              flt_hit;

  wgc_range_filter #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_flt (
    .val_i (s1_word_q),
    .lo_i  (bound_lo),
    .hi_i  (bound_hi),
    .en_i  (filt_en),
    .val_o (flt_word),
    .hit_o (flt_hit)
  );

  logic              s2_valid_q, s2_valid_d;
  logic [WORD_W-1:0] s2_word_q;
  logic              s2_corr_q, s2_uncorr_q, s2_hit_q;
  logic              s2_load;

  assign s2_valid_d = s1_valid_q;
  assign s2_load    = s1_valid_q;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) s2_valid_q <= 1'b0;
    else             s2_valid_q <= s2_valid_d;
  end

  always_ff @(posedge clk) begin
    if (s2_load) begin
      s2_word_q   <= flt_word;
      s2_corr_q   <= s1_corr_q;
      s2_uncorr_q <= s1_uncorr_q;
      s2_hit_q    <= flt_hit;
    end
  end

  assign rd_valid_out     = s2_valid_q;
  assign rd_weight        = s2_word_q;
  assign rd_corrected     = s2_corr_q;
  assign rd_uncorrectable = s2_uncorr_q;
  assign rd_filtered      = s2_hit_q;

endmodule

// File: rtl/wgc_checker.sv
module wgc_checker #(
  parameter int unsigned EXP_W = 8,
  parameter int unsigned MAN_W = 23,
  parameter int unsigned PAR_W = 4
) (
  input logic                 clk,
  input logic                 rst_q_n,
  input logic                 code_en,
  input logic                 filt_en,
  input logic [EXP_W+MAN_W:0] wr_weight,
  input logic [EXP_W+MAN_W:0] wr_word,
  input logic                 rd_valid_in,
  input logic                 rd_valid_out,
  input logic [EXP_W+MAN_W:0] rd_weight,
  input logic                 rd_corrected,
  input logic                 rd_uncorrectable,
  input logic                 rd_filtered
);

  localparam int unsigned WORD_W = 1 + EXP_W + MAN_W;

  logic [1:0] since_rst;

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n)              since_rst <= 2'd0;
    else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
  end

  p_wr_keep_r1: assert property (@(posedge clk) disable iff (!rst_q_n)
    code_en |-> wr_word[WORD_W-1:PAR_W] == wr_weight[WORD_W-1:PAR_W]);

  p_wr_pass_r6: assert property (@(posedge clk) disable iff (!rst_q_n)
    !code_en |-> wr_word == wr_weight);

  p_lsb_clear_r2: assert property (@(posedge clk) disable iff (!rst_q_n)
    (since_rst >= 2'd2 && rd_valid_out && $past(code_en, 2)) |-> rd_weight[PAR_W-1:0] == '0);

  p_flag_excl_r5: assert property (@(posedge clk) disable iff (!rst_q_n)
    rd_valid_out |-> !(rd_corrected && rd_uncorrectable));

  p_zeroed_r7: assert property (@(posedge clk) disable iff (!rst_q_n)
    (rd_valid_out && rd_filtered) |-> rd_weight == '0);

  p_no_full_exp_r8: assert property (@(posedge clk) disable iff (!rst_q_n)
    (since_rst >= 2'd1 && rd_valid_out && $past(filt_en)) |-> !(&rd_weight[WORD_W-2:MAN_W]));

  p_filt_off_r9: assert property (@(posedge clk) disable iff (!rst_q_n)
    (since_rst >= 2'd1 && rd_valid_out && !$past(filt_en)) |-> !rd_filtered);

  p_latency_r11: assert property (@(posedge clk) disable iff (!rst_q_n)
    since_rst >= 2'd2 |-> rd_valid_out == $past(rd_valid_in, 2));

endmodule

bind wgc_top wgc_checker #(.EXP_W(EXP_W), .MAN_W(MAN_W), .PAR_W(PAR_W)) u_chk (
  .clk              (clk),
  .rst_q_n          (rst_sync_n),
  .code_en          (code_en),
  .filt_en          (filt_en),
  .wr_weight        (wr_weight),
  .wr_word          (wr_word),
  .rd_valid_in      (rd_valid_in),
  .rd_valid_out     (rd_valid_out),
  .rd_weight        (rd_weight),
  .rd_corrected     (rd_corrected),
  .rd_uncorrectable (rd_uncorrectable),
  .rd_filtered      (rd_filtered)
);

// File: tb/wgc_top_tb_top.sv
`timescale 1ns/1ps
module wgc_top_tb_top;

  logic        clk;
  logic        rst_n;
  logic        code_en, filt_en;
  logic [31:0] bound_lo, bound_hi;
  logic [31:0] wr_weight, wr_word;
  logic        rd_valid_in;
  logic [31:0] rd_word;
  logic        rd_valid_out;
  logic [31:0] rd_weight;
  logic        rd_corrected, rd_uncorrectable, rd_filtered;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  wgc_top dut_i (
    .clk (clk), .rst_n (rst_n), .code_en (code_en), .filt_en (filt_en),
    .bound_lo (bound_lo), .bound_hi (bound_hi),
    .wr_weight (wr_weight), .wr_word (wr_word),
    .rd_valid_in (rd_valid_in), .rd_word (rd_word),
    .rd_valid_out (rd_valid_out), .rd_weight (rd_weight),
    .rd_corrected (rd_corrected), .rd_uncorrectable (rd_uncorrectable),
    .rd_filtered (rd_filtered)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // kind: 0 = raw with low 4 bits cleared, 1 = zero,
  //       2 = damaged word with low 4 bits cleared, 3 = damaged word untouched
  typedef struct packed {
    logic [3:0]  req;
    logic        code;
    logic        filt;
    logic [31:0] raw;
    logic [31:0] mask;
    logic [1:0]  kind;
    logic        c;
    logic        u;
    logic        f;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VECS [NV] = '{
    '{4'd2,  1'b1, 1'b0, 32'h3F40000B, 32'h00000000, 2'd0, 1'b0, 1'b0, 1'b0}, // R2 clean
    '{4'd3,  1'b1, 1'b0, 32'hBFA00000, 32'h80000000, 2'd0, 1'b1, 1'b0, 1'b0}, // R3 sign
    '{4'd3,  1'b1, 1'b0, 32'h3F000000, 32'h40000000, 2'd0, 1'b1, 1'b0, 1'b0}, // R3 exp msb
    '{4'd3,  1'b1, 1'b0, 32'h3FC00000, 32'h00800000, 2'd0, 1'b1, 1'b0, 1'b0}, // R3 exp lsb
    '{4'd4,  1'b1, 1'b0, 32'h3F000000, 32'h00000004, 2'd0, 1'b1, 1'b0, 1'b0}, // R4 check bit
    '{4'd5,  1'b1, 1'b0, 32'h3F000000, 32'h02000008, 2'd2, 1'b0, 1'b1, 1'b0}, // R5 syndrome 14
    '{4'd6,  1'b0, 1'b0, 32'h3F40000B, 32'h40000000, 2'd3, 1'b0, 1'b0, 1'b0}, // R6 code off
    '{4'd7,  1'b0, 1'b1, 32'h3F400000, 32'h00000000, 2'd3, 1'b0, 1'b0, 1'b0}, // R7 inside
    '{4'd7,  1'b0, 1'b1, 32'h40400000, 32'h00000000, 2'd1, 1'b0, 1'b0, 1'b1}, // R7 above
    '{4'd7,  1'b0, 1'b1, 32'hC0400000, 32'h00000000, 2'd1, 1'b0, 1'b0, 1'b1}, // R7 below
    '{4'd7,  1'b0, 1'b1, 32'h40000000, 32'h00000000, 2'd3, 1'b0, 1'b0, 1'b0}, // R7 equal hi
    '{4'd7,  1'b0, 1'b1, 32'hC0000000, 32'h00000000, 2'd3, 1'b0, 1'b0, 1'b0}, // R7 equal lo
    '{4'd10, 1'b1, 1'b1, 32'h3F000000, 32'h40000000, 2'd0, 1'b1, 1'b0, 1'b0}, // R10 fixed then kept
    '{4'd10, 1'b1, 1'b1, 32'h3F000000, 32'h60000000, 2'd1, 1'b1, 1'b0, 1'b1}, // R10 miscorrect caught
    '{4'd8,  1'b1, 1'b1, 32'h3F000000, 32'h40800000, 2'd1, 1'b0, 1'b1, 1'b1}, // R8 syndrome 15
    '{4'd9,  1'b0, 1'b0, 32'h40400000, 32'h00000000, 2'd3, 1'b0, 1'b0, 1'b0}  // R9 filter off
  };

  // Check bits per R1, written out per position.
  function automatic logic [3:0] ref_chk(logic [31:0] w);
    logic [8:0] d;
    logic [3:0] c;
    d = {w[31], w[30:23]};
    c[0] = d[0] ^ d[1] ^ d[3] ^ d[4] ^ d[6] ^ d[8];
    c[1] = d[0] ^ d[2] ^ d[3] ^ d[5] ^ d[6];
    c[2] = d[1] ^ d[2] ^ d[3] ^ d[7] ^ d[8];
    c[3] = d[4] ^ d[5] ^ d[6] ^ d[7] ^ d[8];
    return c;
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  endtask

  task automatic read_one(input logic [31:0] w);
    @(posedge clk); #1;
    rd_word = w; rd_valid_in = 1'b1;
    @(posedge clk); #1;
    rd_valid_in = 1'b0;
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #1_000_000;
    n_checks++; n_fail++;
    $display("FAIL watchdog actual=%08h expected=%08h", 32'd0, 32'd1);
    finish_up();
  end

  initial begin
    logic [31:0] stored, expw;
    rst_n = 1'b0; code_en = 1'b0; filt_en = 1'b0;
    bound_lo = 32'hC0000000; bound_hi = 32'h40000000;
    wr_weight = '0; rd_valid_in = 1'b0; rd_word = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(rd_valid_out == 1'b0, "R12 in reset", {31'd0, rd_valid_out}, 32'd0);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    check(rd_valid_out == 1'b0, "R12 after release", {31'd0, rd_valid_out}, 32'd0);

    // R1 write path, hand-derived word for 0.5
    code_en = 1'b1; wr_weight = 32'h3F000000; #1;
    check(wr_word == 32'h3F00000C, "R1 check bits", wr_word, 32'h3F00000C);
    wr_weight = 32'hBFA00007; #1;
    check(wr_word == {wr_weight[31:4], ref_chk(wr_weight)}, "R1 check bits neg", wr_word,
          {wr_weight[31:4], ref_chk(wr_weight)});
    code_en = 1'b0; #1;
    check(wr_word == 32'hBFA00007, "R6 write pass", wr_word, 32'hBFA00007);

    for (int i = 0; i < NV; i++) begin
      vec_t v;
      string tag;
      v = VECS[i];
      tag = $sformatf("R%0d vec%0d", v.req, i);
      code_en = v.code; filt_en = v.filt;
      wr_weight = v.raw; #1;
      stored = wr_word ^ v.mask;
      read_one(stored);
      case (v.kind)
        2'd0:    expw = v.raw & 32'hFFFFFFF0;
        2'd1:    expw = 32'd0;
        2'd2:    expw = (v.raw ^ v.mask) & 32'hFFFFFFF0;
        default: expw = v.raw ^ v.mask;
      endcase
      check(rd_weight == expw, tag, rd_weight, expw);
      check({rd_valid_out, rd_corrected, rd_uncorrectable, rd_filtered} == {1'b1, v.c, v.u, v.f},
            tag, {28'd0, rd_valid_out, rd_corrected, rd_uncorrectable, rd_filtered},
            {28'd0, 1'b1, v.c, v.u, v.f});
    end

    // R8 infinity inside wide bounds
    code_en = 1'b0; filt_en = 1'b1;
    bound_lo = 32'hFF800000; bound_hi = 32'h7F800000;
    read_one(32'h7F800000);
    check(rd_weight == 32'd0 && rd_filtered, "R8 inf", rd_weight, 32'd0);
    read_one(32'h3F800000);
    check(rd_weight == 32'h3F800000 && !rd_filtered, "R8 normal kept", rd_weight, 32'h3F800000);

    // R11 back-to-back stream
    filt_en = 1'b0;
    @(posedge clk); #1; rd_word = 32'h11111111; rd_valid_in = 1'b1;
    @(posedge clk); #1; rd_word = 32'h22222222;
    @(posedge clk); #1; rd_word = 32'h33333333;
    @(negedge clk);
    check(rd_valid_out && rd_weight == 32'h11111111, "R11 first", rd_weight, 32'h11111111);
    @(posedge clk); #1; rd_valid_in = 1'b0;
    @(negedge clk);
    check(rd_valid_out && rd_weight == 32'h22222222, "R11 second", rd_weight, 32'h22222222);
    @(negedge clk);
    check(rd_valid_out && rd_weight == 32'h33333333, "R11 third", rd_weight, 32'h33333333);
    @(negedge clk);
    check(rd_valid_out == 1'b0, "R11 drain", {31'd0, rd_valid_out}, 32'd0);

    finish_up();
  end

endmodule